// File: doc/BRIEF.md
# Memory Line Fill and Check Engine

This engine writes and reads memory one line at a time, through a request/grant master port, with no processor help once it is started. In initialization mode it covers the whole populated space, from line zero up to the configured line count. It writes an all-zero line at each address, so the downstream controller stores a valid check code everywhere.

In test mode it fills an inclusive byte-address range, one line per request, from a selected data source. The source is one of eight fixed byte patterns, a pseudo-random sequence, a walking one, or a line supplied by software together with its check bits. When verify is enabled, the engine then reads the same range back and compares each returned line against data it regenerates itself. It records the first mismatching address, and it can either halt at that point or run to the end of the range.

The controller has four states. `S_IDLE` waits for `start`. `S_FILL` issues writes and moves to `S_RD` or back to `S_IDLE` after the last write is accepted. `S_RD` issues one read and moves to `S_WAIT` on grant. `S_WAIT` waits for the response, then returns to `S_RD` for the next line or to `S_IDLE` when the range ends or a stop on error happens. A start that finds an empty range stays in `S_IDLE`.

Top module: `line_fill_check`

## Requirements
- R1: With `cfg_init_mode`=1 the engine writes an all-zero line at every line index 0 to `cfg_size_lines`-1, in ascending order, with `mem_ecc_ovr`=0. No verify pass follows, even when `cfg_verify`=1.
- R2: In test mode the written lines run from the line of `cfg_start_addr` up to the line of `cfg_end_addr` inclusive. Line index k is at byte address k*64, and address bits [5:0] of both bounds are ignored. An end below the start, or a size of 0 in init mode, issues no request, and `done` is set one cycle after `start`.
- R3: `cfg_src`=0 selects a fixed pattern: every byte of the line equals the byte chosen by `cfg_pat_sel`. The codes 0 to 7 select 00, FF, 55, AA, 33, CC, 0F and F0 in that order.
- R4: `cfg_src`=1 selects pseudo-random data. Line 0 of the range uses the seed (a seed of 0 is replaced by 1). Each following line applies one xorshift step: s^=s<<13, s^=s>>17, s^=s<<5. The 32-bit state is repeated across the line.
- R5: `cfg_src`=2 selects a walking one: line k of the range has only bit (k mod line width) set, so the one wraps back to bit 0 after the top bit.
- R6: `cfg_src`=3 writes `cfg_line_data` with `cfg_line_ecc` on `mem_wecc` and `mem_ecc_ovr`=1. The verify pass then compares `mem_recc` as well as the data.
- R7: With verify enabled, after the last write is accepted the engine reads the same lines in the same order, with one read outstanding. It compares each response against regenerated data, with the sequence restarted from the first line of the range.
- R8: The first miscompare sets `err` and latches its line address in `err_addr`. Later miscompares leave `err_addr` unchanged, and both are cleared by the next `start`.
- R9: With `cfg_stop_on_err`=1 the engine finishes right after the first mismatching response and issues no further reads. With it at 0, it reads the whole range.
- R10: `busy` is 1 from the cycle after `start` until the cycle after the final accepted write or final read response. `done` is set as `busy` falls and stays set until the next `start`. After reset all status outputs are 0.
- R11: A request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until a cycle in which `mem_gnt` is 1, and that cycle completes the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse, taken while idle |
| cfg_init_mode | input | 1 | 1 = zero initialization, 0 = test |
| cfg_size_lines | input | ADDR_W-5 | Populated size in lines (init mode) |
| cfg_start_addr | input | ADDR_W | First byte address of the test range |
| cfg_end_addr | input | ADDR_W | Last byte address of the test range |
| cfg_src | input | 2 | Data source: 0 fixed, 1 random, 2 walking, 3 explicit line |
| cfg_pat_sel | input | 3 | Fixed pattern select |
| cfg_seed | input | 32 | Random sequence seed |
| cfg_line_data | input | LINE_W | Explicit line data |
| cfg_line_ecc | input | ECC_W | Explicit line check bits |
| cfg_verify | input | 1 | Read back and compare after fill |
| cfg_stop_on_err | input | 1 | Halt at first miscompare |
| mem_req | output | 1 | Line request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Line byte address |
| mem_wdata | output | LINE_W | Write data |
| mem_wecc | output | ECC_W | Write check bits (explicit line only) |
| mem_ecc_ovr | output | 1 | Use `mem_wecc` instead of generated check bits |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | LINE_W | Read response data |
| mem_recc | input | ECC_W | Read response check bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation finished |
| err | output | 1 | A miscompare was seen |
| err_addr | output | ADDR_W | Address of the first miscompare |

## Verification
The bench builds the engine with a 16-bit address, a 32-bit line and 4 check bits. A 32-bit line lets the walking one wrap within a 40-line range. It also makes each random line equal to one xorshift state, so the reference sequence is easy to compute. The narrow address keeps the range bounds and `err_addr` small, while offsets inside a line can still be tested. Grants are withheld on every third cycle and read latency alternates between one and two cycles, which exercises request holding and the wait state.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

    localparam int LINE_OFS = 6;

    typedef enum logic [1:0] {
        SRC_FIXED = 2'd0,
        SRC_RAND  = 2'd1,
        SRC_WALK  = 2'd2,
        SRC_LINE  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FILL,
        S_RD,
        S_WAIT
    } state_e;

    function automatic logic [31:0] xs_step(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

endpackage

// File: rtl/lfc_patgen.sv
module lfc_patgen
    import lfc_pkg::*;
#(
    parameter int LINE_W = 512,
    parameter int ECC_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    input  src_e              src,
    input  logic [2:0]        pat_sel,
    input  logic [31:0]       seed,
    input  logic [LINE_W-1:0] line_data,
    input  logic [ECC_W-1:0]  line_ecc,
    output logic [LINE_W-1:0] data,
    output logic [ECC_W-1:0]  ecc,
    output logic              ecc_ovr
);
    localparam int N_WORDS = LINE_W / 32;
    localparam int N_BYTES = LINE_W / 8;

    logic [LINE_W-1:0] walk_q;
    logic [31:0]       rnd_q;
    logic [7:0]        fix_byte;
    logic [LINE_W-1:0] fix_line;
    logic [LINE_W-1:0] rnd_line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= LINE_W'(1);
            rnd_q  <= 32'd1;
        end else if (restart) begin
            walk_q <= LINE_W'(1);
            rnd_q  <= (seed == 32'd0) ? 32'd1 : seed;
        end else if (advance) begin
            walk_q <= {walk_q[LINE_W-2:0], walk_q[LINE_W-1]};
            rnd_q  <= xs_step(rnd_q);
        end
    end

    always_comb begin
        unique case (pat_sel)
            3'd0: fix_byte = 8'h00;
            3'd1: fix_byte = 8'hFF;
            3'd2: fix_byte = 8'h55;
            3'd3: fix_byte = 8'hAA;
            3'd4: fix_byte = 8'h33;
            3'd5: fix_byte = 8'hCC;
            3'd6: fix_byte = 8'h0F;
            3'd7: fix_byte = 8'hF0;
        endcase
    end

    for (genvar gb = 0; gb < N_BYTES; gb++) begin : g_fix
        assign fix_line[gb*8 +: 8] = fix_byte;
    end

    for (genvar gw = 0; gw < N_WORDS; gw++) begin : g_rnd
        assign rnd_line[gw*32 +: 32] = rnd_q;
    end

    always_comb begin
        unique case (src)
            SRC_FIXED: data = fix_line;
            SRC_RAND:  data = rnd_line;
            SRC_WALK:  data = walk_q;
            SRC_LINE:  data = line_data;
        endcase
        ecc_ovr = (src == SRC_LINE);
        ecc     = ecc_ovr ? line_ecc : '0;
    end

endmodule

// File: rtl/lfc_range.sv
module lfc_range #(
    parameter int IDX_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             rewind,
    input  logic             advance,
    input  logic [IDX_W-1:0] first,
    input  logic [IDX_W-1:0] last,
    output logic [IDX_W-1:0] cur,
    output logic             at_last
);
    logic [IDX_W-1:0] first_q, last_q, cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= '0;
            last_q  <= '0;
            cur_q   <= '0;
        end else if (load) begin
            first_q <= first;
            last_q  <= last;
            cur_q   <= first;
        end else if (rewind) begin
            cur_q <= first_q;
        end else if (advance) begin
            cur_q <= cur_q + 1'b1;
        end
    end

    assign cur     = cur_q;
    assign at_last = (cur_q == last_q);

endmodule

// File: rtl/line_fill_check.sv
module line_fill_check
    import lfc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 512,
    parameter int ECC_W  = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  cfg_init_mode,
    input  logic [ADDR_W-LINE_OFS:0] cfg_size_lines,
    input  logic [ADDR_W-1:0]     cfg_start_addr,
    input  logic [ADDR_W-1:0]     cfg_end_addr,
    input  logic [1:0]            cfg_src,
    input  logic [2:0]            cfg_pat_sel,
    input  logic [31:0]           cfg_seed,
    input  logic [LINE_W-1:0]     cfg_line_data,
    input  logic [ECC_W-1:0]      cfg_line_ecc,
    input  logic                  cfg_verify,
    input  logic                  cfg_stop_on_err,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [LINE_W-1:0]     mem_wdata,
    output logic [ECC_W-1:0]      mem_wecc,
    output logic                  mem_ecc_ovr,
    input  logic                  mem_gnt,
    input  logic                  mem_rvalid,
    input  logic [LINE_W-1:0]     mem_rdata,
    input  logic [ECC_W-1:0]      mem_recc,
    output logic                  busy,
    output logic                  done,
    output logic                  err,
    output logic [ADDR_W-1:0]     err_addr
);
    localparam int IDX_W = ADDR_W - LINE_OFS;

    state_e state_q, state_d;

    src_e       src_q;
    logic [2:0] pat_q;
    logic       verify_q, stop_q;

    logic [IDX_W-1:0] first_idx, last_idx, cur_idx;
    logic             range_empty, at_last;
    logic             start_ok;
    logic             rng_adv, rng_rewind;
    logic             gen_restart;
    logic [LINE_W-1:0] gen_data;
    logic [ECC_W-1:0]  gen_ecc;
    logic              gen_ovr;
    logic              miss, resp_ok, finish;

    // range bounds for the two modes
    always_comb begin
        if (cfg_init_mode) begin
            first_idx   = '0;
            last_idx    = IDX_W'(cfg_size_lines - 1'b1);
            range_empty = (cfg_size_lines == '0);
        end else begin
            first_idx   = cfg_start_addr[ADDR_W-1:LINE_OFS];
            last_idx    = cfg_end_addr[ADDR_W-1:LINE_OFS];
            range_empty = (last_idx < first_idx);
        end
    end

    assign start_ok = (state_q == S_IDLE) && start;
    assign miss     = (mem_rdata != gen_data) || (gen_ovr && (mem_recc != gen_ecc));
    assign resp_ok  = (state_q == S_WAIT) && mem_rvalid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start && !range_empty) state_d = S_FILL;
            S_FILL: if (mem_gnt && at_last)    state_d = verify_q ? S_RD : S_IDLE;
            S_RD:   if (mem_gnt)               state_d = S_WAIT;
            S_WAIT: if (mem_rvalid)            state_d = ((miss && stop_q) || at_last) ? S_IDLE : S_RD;
        endcase
    end

    // control and port outputs
    always_comb begin
        mem_req     = (state_q == S_FILL) || (state_q == S_RD);
        mem_we      = (state_q == S_FILL);
        mem_addr    = {cur_idx, {LINE_OFS{1'b0}}};
        mem_wdata   = gen_data;
        mem_wecc    = gen_ecc;
        mem_ecc_ovr = gen_ovr && (state_q == S_FILL);
        busy        = (state_q != S_IDLE);
        rng_rewind  = (state_q == S_FILL) && mem_gnt && at_last && verify_q;
        rng_adv     = ((state_q == S_FILL) && mem_gnt && !at_last)
                    || (resp_ok && !at_last && !(miss && stop_q));
        gen_restart = start_ok || rng_rewind;
        finish      = ((state_q == S_FILL) && mem_gnt && at_last && !verify_q)
                    || (resp_ok && ((miss && stop_q) || at_last))
                    || (start_ok && range_empty);
    end

    // latched controls and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= SRC_FIXED;
            pat_q    <= '0;
            verify_q <= 1'b0;
            stop_q   <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            err_addr <= '0;
        end else begin
            if (start_ok) begin
                src_q    <= cfg_init_mode ? SRC_FIXED : src_e'(cfg_src);
                pat_q    <= cfg_init_mode ? 3'd0 : cfg_pat_sel;
                verify_q <= cfg_verify && !cfg_init_mode;
                stop_q   <= cfg_stop_on_err;
                err      <= 1'b0;
                err_addr <= '0;
            end else if (resp_ok && miss && !err) begin
                err      <= 1'b1;
                err_addr <= mem_addr;
            end
            if (finish)        done <= 1'b1;
            else if (start_ok) done <= 1'b0;
        end
    end

    lfc_range #(.IDX_W(IDX_W)) u_range (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_ok),
        .rewind  (rng_rewind),
        .advance (rng_adv),
        .first   (first_idx),
        .last    (last_idx),
        .cur     (cur_idx),
        .at_last (at_last)
    );

    lfc_patgen #(.LINE_W(LINE_W), .ECC_W(ECC_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (gen_restart),
        .advance   (rng_adv),
        .src       (src_q),
        .pat_sel   (pat_q),
        .seed      (cfg_seed),
        .line_data (cfg_line_data),
        .line_ecc  (cfg_line_ecc),
        .data      (gen_data),
        .ecc       (gen_ecc),
        .ecc_ovr   (gen_ovr)
    );

endmodule

// File: rtl/lfc_chk.sv
module lfc_chk #(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              cfg_init_mode,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LINE_W-1:0] mem_wdata,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] err_addr
);
    p_req_within_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    p_done_excl_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_fall_sets_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_hold_until_gnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> (err && $stable(err_addr)));

    p_init_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && cfg_init_mode) |-> (mem_wdata == '0));

endmodule

bind line_fill_check lfc_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (.*);

// File: tb/sim_line_fill_check.sv
module sim_line_fill_check;
    localparam int AW  = 16;
    localparam int LW  = 32;
    localparam int EW  = 4;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cfg_init_mode = 1'b0;
    logic [AW-6:0] cfg_size_lines = '0;
    logic [AW-1:0] cfg_start_addr = '0, cfg_end_addr = '0;
    logic [1:0] cfg_src = '0;
    logic [2:0] cfg_pat_sel = '0;
    logic [31:0] cfg_seed = '0;
    logic [LW-1:0] cfg_line_data = '0;
    logic [EW-1:0] cfg_line_ecc = '0;
    logic cfg_verify = 1'b0, cfg_stop_on_err = 1'b0;
    logic mem_req, mem_we, mem_ecc_ovr;
    logic [AW-1:0] mem_addr;
    logic [LW-1:0] mem_wdata;
    logic [EW-1:0] mem_wecc;
    logic mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [LW-1:0] mem_rdata = '0;
    logic [EW-1:0] mem_recc = '0;
    logic busy, done, err;
    logic [AW-1:0] err_addr;

    always #5 clk = ~clk;

    line_fill_check #(.ADDR_W(AW), .LINE_W(LW), .ECC_W(EW)) u0 (.*);

    int n_chk = 0, n_fail = 0, cyc = 0, n_rd = 0;
    bit r_busy = 0, r_done = 0, r_err = 0, r_verify = 0, r_stop = 0, r_init = 0;
    logic [AW-1:0] r_err_addr = '0;
    int r_phase = 0, r_k = 0, r_n = 0, r_base = 0, r_src = 0, r_pat = 0, r_wcnt = 0;
    logic [31:0] r_seed = '0;
    logic [LW-1:0] mem_arr [int];
    logic [EW-1:0] ecc_arr [int];
    int bad_a = -1, bad_b = -1;
    bit start_now = 0;

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] exp_data(int k);
        logic [7:0] b;
        logic [31:0] s;
        logic [LW-1:0] d;
        if (r_init) return '0;
        case (r_src)
            0: begin
                case (r_pat)
                    0: b = 8'h00; 1: b = 8'hFF; 2: b = 8'h55; 3: b = 8'hAA;
                    4: b = 8'h33; 5: b = 8'hCC; 6: b = 8'h0F; default: b = 8'hF0;
                endcase
                d = {(LW/8){b}};
            end
            1: begin
                s = (r_seed == 0) ? 32'd1 : r_seed;
                for (int i = 0; i < k; i++) begin
                    s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
                end
                d = {(LW/32){s}};
            end
            2: d = LW'(1) << (k % LW);
            default: d = cfg_line_data;
        endcase
        return d;
    endfunction

    function automatic string data_tag();
        if (r_init) return "R1";
        case (r_src)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic tick();
        bit exp_req, rv, ovr, miss;
        int a, e;
        logic [LW-1:0] rd;
        logic [EW-1:0] re;
        @(negedge clk);
        cyc++;
        // compare against the reference state for this cycle
        chk(busy == r_busy, "R10", "busy", 64'(busy), 64'(r_busy));
        chk(done == r_done, "R10", "done", 64'(done), 64'(r_done));
        chk(err == r_err, "R8", "err", 64'(err), 64'(r_err));
        if (r_err) chk(err_addr == r_err_addr, "R8", "err_addr", 64'(err_addr), 64'(r_err_addr));
        exp_req = (r_phase == 1) || (r_phase == 2);
        ovr = !r_init && (r_src == 3);
        chk(mem_req == exp_req, (r_phase >= 2) ? "R7" : "R2", "mem_req", 64'(mem_req), 64'(exp_req));
        if (exp_req && mem_req) begin
            chk(mem_addr == AW'((r_base + r_k) * 64), (r_phase == 2) ? "R7" : "R2", "mem_addr",
                64'(mem_addr), 64'((r_base + r_k) * 64));
            chk(mem_we == (r_phase == 1), "R7", "mem_we", 64'(mem_we), 64'(r_phase == 1));
            if (r_phase == 1) begin
                chk(mem_wdata == exp_data(r_k), data_tag(), "mem_wdata", 64'(mem_wdata), 64'(exp_data(r_k)));
                chk(mem_ecc_ovr == ovr, ovr ? "R6" : "R1", "mem_ecc_ovr", 64'(mem_ecc_ovr), 64'(ovr));
                if (ovr) chk(mem_wecc == cfg_line_ecc, "R6", "mem_wecc", 64'(mem_wecc), 64'(cfg_line_ecc));
            end
        end
        // drive stimulus for the next edge
        mem_gnt = (cyc % 3) != 2;
        start   = start_now;
        rv = (r_phase == 3) && (r_wcnt >= (r_k % 2));
        mem_rvalid = rv;
        a = r_base + r_k;
        if (rv) begin
            rd = mem_arr.exists(a) ? mem_arr[a] : '0;
            re = ecc_arr.exists(a) ? ecc_arr[a] : '0;
            if (a == bad_a || a == bad_b) rd = rd ^ LW'(1);
            mem_rdata = rd;
            mem_recc  = re;
        end
        if (mem_req && mem_we && mem_gnt) begin
            mem_arr[int'(mem_addr >> 6)] = mem_wdata;
            ecc_arr[int'(mem_addr >> 6)] = mem_ecc_ovr ? mem_wecc : '0;
        end
        // advance the reference across the coming edge
        if (start_now && r_phase == 0) begin
            r_init = cfg_init_mode; r_src = cfg_src; r_pat = cfg_pat_sel; r_seed = cfg_seed;
            r_stop = cfg_stop_on_err; r_verify = cfg_verify && !cfg_init_mode;
            r_err = 0; r_err_addr = '0; r_k = 0; n_rd = 0;
            if (cfg_init_mode) begin
                r_base = 0; r_n = int'(cfg_size_lines);
            end else begin
                r_base = int'(cfg_start_addr >> 6); e = int'(cfg_end_addr >> 6);
                r_n = (e >= r_base) ? e - r_base + 1 : 0;
            end
            if (r_n == 0) begin r_done = 1; r_busy = 0; end
            else begin r_done = 0; r_busy = 1; r_phase = 1; end
        end else begin
            case (r_phase)
                1: if (mem_gnt) begin
                    if (r_k == r_n - 1) begin
                        r_k = 0;
                        if (r_verify) r_phase = 2;
                        else begin r_phase = 0; r_busy = 0; r_done = 1; end
                    end else r_k++;
                end
                2: if (mem_gnt) begin r_phase = 3; r_wcnt = 0; n_rd++; end
                3: if (rv) begin
                    miss = (mem_rdata != exp_data(r_k)) || (ovr && mem_recc != cfg_line_ecc);
                    if (miss && !r_err) begin r_err = 1; r_err_addr = AW'(a * 64); end
                    if ((miss && r_stop) || r_k == r_n - 1) begin r_phase = 0; r_busy = 0; r_done = 1; end
                    else begin r_k++; r_phase = 2; end
                end else r_wcnt++;
                default: ;
            endcase
        end
    endtask

    task automatic run();
        start_now = 1; tick(); start_now = 0;
        while (r_phase != 0 && cyc < LIMIT) tick();
        tick();
        if (cyc >= LIMIT) chk(0, "R10", "watchdog", 64'(cyc), 64'(LIMIT));
    endtask

    task automatic set_test(int src, int pat, int s_addr, int e_addr, bit ver, bit stp);
        cfg_init_mode = 0; cfg_src = 2'(src); cfg_pat_sel = 3'(pat);
        cfg_start_addr = AW'(s_addr); cfg_end_addr = AW'(e_addr);
        cfg_verify = ver; cfg_stop_on_err = stp;
    endtask

    initial begin
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1'b1;
        tick();
        // R10: reset state
        chk(busy == 0 && done == 0 && err == 0 && mem_req == 0, "R10", "reset status",
            {busy, done, err, mem_req}, 64'd0);

        // R1: init of 5 lines, verify request ignored
        cfg_init_mode = 1; cfg_size_lines = 5; cfg_verify = 1;
        for (int i = 0; i < 5; i++) mem_arr[i] = '1;
        run();
        for (int i = 0; i < 5; i++) chk(mem_arr[i] == '0, "R1", "init line", 64'(mem_arr[i]), 64'd0);
        chk(n_rd == 0, "R1", "reads after init", 64'(n_rd), 64'd0);

        // R2: empty ranges
        cfg_size_lines = 0; run();
        chk(done == 1 && n_rd == 0, "R2", "empty init done", 64'(done), 64'd1);
        set_test(0, 1, 'h400, 'h3C0, 1, 0); run();
        chk(done == 1, "R2", "end below start done", 64'(done), 64'd1);

        // R3 / R7: fixed pattern with verify, then unaligned bounds
        set_test(0, 2, 'h100, 'h1C0, 1, 0); run();
        chk(n_rd == 4 && err == 0, "R7", "verify reads", 64'(n_rd), 64'd4);
        set_test(0, 7, 'h213, 'h2FF, 0, 0); run();
        chk(mem_arr['h0B] == 32'hF0F0F0F0, "R3", "pattern 7 last line", 64'(mem_arr['h0B]), 64'hF0F0F0F0);
        set_test(0, 4, 'h300, 'h340, 1, 0); run();

        // R4: random data, nonzero and zero seed
        cfg_seed = 32'h0000ACE1; set_test(1, 0, 'h800, 'hBC0, 1, 0); run();
        chk(err == 0, "R4", "random verify clean", 64'(err), 64'd0);
        cfg_seed = 32'd0; set_test(1, 0, 'h000, 'h1C0, 1, 0); run();
        chk(mem_arr[0] == 32'd1, "R4", "zero seed line", 64'(mem_arr[0]), 64'd1);

        // R5: walking one across a wrap
        set_test(2, 0, 'h1000, 'h1000 + 39 * 64, 1, 0); run();
        chk(mem_arr['h40 + 32] == 32'd1, "R5", "walk wrap", 64'(mem_arr['h40 + 32]), 64'd1);

        // R6: explicit line with check bits
        cfg_line_data = 32'hDEADBEEF; cfg_line_ecc = 4'hA;
        set_test(3, 0, 'h2000, 'h20C0, 1, 0); run();
        chk(ecc_arr['h80] == 4'hA && err == 0, "R6", "explicit ecc", 64'(ecc_arr['h80]), 64'hA);

        // R8 / R9: two corrupt lines, run on
        bad_a = 'h12; bad_b = 'h15;
        set_test(0, 5, 'h400, 'h5C0, 1, 0); run();
        chk(err == 1 && err_addr == AW'('h12 * 64), "R8", "first miss addr", 64'(err_addr), 64'('h12 * 64));
        chk(n_rd == 8, "R9", "reads without stop", 64'(n_rd), 64'd8);

        // R9: stop at first miscompare
        set_test(0, 5, 'h400, 'h5C0, 1, 1); run();
        chk(n_rd == 3 && done == 1, "R9", "reads with stop", 64'(n_rd), 64'd3);

        // R8: cleared by next start
        bad_a = -1; bad_b = -1;
        set_test(0, 6, 'h600, 'h640, 1, 0); run();
        chk(err == 0, "R8", "err cleared", 64'(err), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule